// File: doc/BRIEF.md
# Manchester Clock Recovery State Machine

This block rebuilds a bit clock from a single-wire Manchester-encoded line. It runs from a local sampling clock that ticks several times per bit cell. In each cell the line always changes level at the midpoint. The block uses that midpoint change as its timing reference and raises a recovered clock strobe just after it. The serial data output is the line itself, passed through without a register. A downstream shift register clocked on the strobe's rising edge therefore captures the value that the line holds in the second half of the cell.

The state is held in exactly two flip-flops. After each strobe the machine runs a two-tick blanking window. During that window it ignores the level change that may occur at the cell boundary. At the end of the window it records the line level. It then waits until the line differs from that recorded level. If the machine starts out of step, an input of two cells with alternating bit values brings it back into step. Once in step, the bits that follow are recovered correctly.

Top module: `manchester_clk_recover`

## Requirements
- R1: `dataOut` equals `lineIn` in every cycle, with no register delay.
- R2: While `rst` is high at a rising clock edge, the machine is forced into its first blanking state. `recClk` is low from the cycle after that edge, and it stays low for at least the two cycles after `rst` falls.
- R3: Every `recClk` pulse is exactly one local clock cycle wide.
- R4: In the two cycles that follow a `recClk` high cycle, `recClk` stays low whatever `lineIn` does.
- R5: Once blanking has ended, a sampled `lineIn` level that differs from the last recorded level makes `recClk` high in the cycle after the sampling edge.
- R6: Once blanking has ended, a sampled `lineIn` that equals the recorded level keeps `recClk` low in the next cycle. The recorded level is then refreshed from the line.
- R7: The test stream uses four local ticks per bit. A bit b is sent as the level !b for two ticks, then the level b for two ticks. When the machine is in step, `dataOut` equals b at each rising edge of `recClk`.
- R8: Start from any state, including after a glitch that knocks the timing out of step. Two cells carrying the bits 1 then 0 bring the machine into step, so every later bit meets R7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Local sampling clock, faster than the bit rate |
| rst | input | 1 | Synchronous reset, active high |
| lineIn | input | 1 | Manchester-encoded serial line |
| recClk | output | 1 | Recovered clock strobe, high for one cycle after each detected mid-cell change |
| dataOut | output | 1 | Serial data, a combinational copy of `lineIn` |

## Verification
`dataOut` is due in the same cycle as `lineIn`, so the bench compares it before it moves the line. `recClk` comes from the state register. It changes one edge after the sample that triggers it: one edge after the differing level for a pulse, then two further edges of blanking. The bench drives the line at the falling edge and advances a behavioural model at the rising edge. At the next falling edge it compares `recClk` with the model's prediction for that cycle. The decoded bit is checked at each predicted rising edge of the strobe, against the value sent in that cell.

// File: rtl/manchester_clk_recover_pkg.sv
package manchester_clk_recover_pkg;

  localparam int STATE_W = 2;

  // State codes: the high bit marks the watch phase, the low bit holds the recorded level there
  localparam logic [STATE_W-1:0] ST_PULSE  = 2'b00;
  localparam logic [STATE_W-1:0] ST_BLANK  = 2'b01;
  localparam logic [STATE_W-1:0] ST_WATCH0 = 2'b10;
  localparam logic [STATE_W-1:0] ST_WATCH1 = 2'b11;
  localparam logic [STATE_W-1:0] ST_RESET  = ST_BLANK;

  typedef struct packed {
    logic [STATE_W-1:0] nextBits;
    logic               clkOut;
  } ctrlStrobe_t;

endpackage

// File: rtl/manchester_clk_recover_ctrl.sv
module manchester_clk_recover_ctrl
  import manchester_clk_recover_pkg::*;
(
  input  logic               lineIn,
  input  logic [STATE_W-1:0] stateBits,
  output ctrlStrobe_t        strobe
);

  logic levelSeen;
  assign levelSeen = stateBits[0];

  always_comb begin
    strobe.nextBits = ST_BLANK;
    strobe.clkOut   = 1'b0;
    unique case (stateBits)
      ST_PULSE: begin
        strobe.clkOut   = 1'b1;
        strobe.nextBits = ST_BLANK;
      end
      ST_BLANK: begin
        strobe.nextBits = {1'b1, lineIn};
      end
      ST_WATCH0, ST_WATCH1: begin
        if (lineIn != levelSeen) begin
          strobe.nextBits = ST_PULSE;
        end else begin
          strobe.nextBits = {1'b1, lineIn};
        end
      end
      default: begin
        strobe.nextBits = ST_BLANK;
      end
    endcase
  end

endmodule

// File: rtl/manchester_clk_recover_dp.sv
module manchester_clk_recover_dp
  import manchester_clk_recover_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               lineIn,
  input  ctrlStrobe_t        strobe,
  output logic [STATE_W-1:0] stateBits,
  output logic               dataOut
);

  logic [STATE_W-1:0] stateQ;

  for (genvar i = 0; i < STATE_W; i++) begin : g_stateFf
    always_ff @(posedge clk) begin
      if (rst) begin
        stateQ[i] <= ST_RESET[i];
      end else begin
        stateQ[i] <= strobe.nextBits[i];
      end
    end
  end

  assign stateBits = stateQ;
  assign dataOut   = lineIn;

endmodule

// File: rtl/manchester_clk_recover.sv
module manchester_clk_recover
  import manchester_clk_recover_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic lineIn,
  output logic recClk,
  output logic dataOut
);

  ctrlStrobe_t        strobe;
  logic [STATE_W-1:0] stateBits;

  manchester_clk_recover_ctrl u_ctrl (
    .lineIn    (lineIn),
    .stateBits (stateBits),
    .strobe    (strobe)
  );

  manchester_clk_recover_dp u_dp (
    .clk       (clk),
    .rst       (rst),
    .lineIn    (lineIn),
    .strobe    (strobe),
    .stateBits (stateBits),
    .dataOut   (dataOut)
  );

  assign recClk = strobe.clkOut;

endmodule

// File: rtl/manchester_clk_recover_chk.sv
module manchester_clk_recover_chk (
  input logic       clk,
  input logic       rst,
  input logic       lineIn,
  input logic       recClk,
  input logic       dataOut,
  input logic [1:0] stateBits
);

  p_data_copy_r1: assert property (@(posedge clk) dataOut == lineIn);

  p_reset_quiet_r2: assert property (@(posedge clk) rst |=> !recClk);

  p_single_width_r3: assert property (@(posedge clk) disable iff (rst)
    recClk |=> !recClk);

  p_blank_window_r4: assert property (@(posedge clk) disable iff (rst)
    recClk |=> ##1 !recClk);

  p_edge_detect_r5: assert property (@(posedge clk) disable iff (rst)
    (stateBits[1] && (lineIn != stateBits[0])) |=> recClk);

  p_level_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (stateBits[1] && (lineIn == stateBits[0])) |=> (!recClk && stateBits[1] && (stateBits[0] == $past(lineIn))));

endmodule

bind manchester_clk_recover manchester_clk_recover_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .lineIn    (lineIn),
  .recClk    (recClk),
  .dataOut   (dataOut),
  .stateBits (stateBits)
);

// File: tb/manchester_clk_recover_tb.sv
`timescale 1ns/1ps
module manchester_clk_recover_tb;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic lineIn = 1'b0;
  logic recClk;
  logic dataOut;

  int compared = 0;
  int mismatched = 0;
  int cycles = 0;
  bit finished = 0;

  // behavioural reference: ticks since the last detected change, and the level recorded
  int  refSince = 1;
  int  prevSince = 1;
  logic refLevel = 1'b0;
  logic refClkPrev = 1'b0;

  always #4 clk = ~clk;

  manchester_clk_recover u_dut (
    .clk     (clk),
    .rst     (rst),
    .lineIn  (lineIn),
    .recClk  (recClk),
    .dataOut (dataOut)
  );

  task automatic check(input logic act, input logic exp, input string tag);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %b expected %b at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  task automatic modelStep(input logic lv, input logic r);
    prevSince = refSince;
    if (r) begin
      refSince = 1;
    end else if (refSince == 0) begin
      refSince = 1;
    end else if (refSince == 1) begin
      refSince = 2;
      refLevel = lv;
    end else if (lv != refLevel) begin
      refSince = 0;
    end else begin
      refLevel = lv;
    end
  endtask

  task automatic tick(input logic lv, input logic chk, input logic bitv, input string bitTag);
    logic expClk;
    string tag;
    lineIn = lv;
    @(posedge clk);
    cycles++;
    modelStep(lv, rst);
    @(negedge clk);
    expClk = (refSince == 0);
    if (rst) tag = "R2";
    else if (expClk) tag = "R5";
    else if (refSince == 1) tag = "R3,R4";
    else if (prevSince == 1) tag = "R4";
    else tag = "R6";
    check(recClk, expClk, tag);
    check(dataOut, lineIn, "R1");
    if (chk && expClk && !refClkPrev) check(dataOut, bitv, bitTag);
    refClkPrev = expClk;
  endtask

  task automatic sendBit(input logic b, input logic chk, input string bitTag);
    tick(!b, 1'b0, b, bitTag);
    tick(!b, 1'b0, b, bitTag);
    tick(b, chk, b, bitTag);
    tick(b, chk, b, bitTag);
  endtask

  task automatic sendWord(input logic [11:0] bits, input int n, input string bitTag);
    for (int i = n - 1; i >= 0; i--) sendBit(bits[i], 1'b1, bitTag);
  endtask

  initial begin
    @(negedge clk);
    // reset held for three edges (R2)
    rst = 1'b1;
    for (int i = 0; i < 3; i++) tick(1'b0, 1'b0, 1'b0, "R2");
    rst = 1'b0;
    // quiet line after release: blanking then steady watch (R2, R6)
    for (int i = 0; i < 6; i++) tick(1'b0, 1'b0, 1'b0, "R6");
    // preamble then data in step (R7)
    sendBit(1'b1, 1'b0, "R8");
    sendBit(1'b0, 1'b0, "R8");
    sendWord(12'b1011_0001_1101, 12, "R7");
    sendWord(12'b1111_0000_0110, 12, "R7");
    // a change inside the blanking window is ignored (R4)
    for (int i = 0; i < 4; i++) tick(1'b0, 1'b0, 1'b0, "R4");
    tick(1'b1, 1'b0, 1'b0, "R5");
    tick(1'b0, 1'b0, 1'b0, "R4");
    tick(1'b1, 1'b0, 1'b0, "R4");
    tick(1'b1, 1'b0, 1'b0, "R6");
    tick(1'b1, 1'b0, 1'b0, "R6");
    // glitches of several lengths knock the timing, then preamble relocks (R8)
    for (int g = 1; g <= 3; g++) begin
      sendBit(1'b0, 1'b0, "R8");
      for (int k = 0; k < g; k++) tick(1'b1, 1'b0, 1'b0, "R8");
      sendBit(1'b1, 1'b0, "R8");
      sendBit(1'b0, 1'b0, "R8");
      sendWord(12'b0010_1101_1001, 12, "R8");
    end
    // mid-stream reset (R2) followed by recovery
    rst = 1'b1;
    tick(1'b1, 1'b0, 1'b0, "R2");
    tick(1'b0, 1'b0, 1'b0, "R2");
    rst = 1'b0;
    sendBit(1'b1, 1'b0, "R8");
    sendBit(1'b0, 1'b0, "R8");
    sendWord(12'b1100_1010_0111, 12, "R7");
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule